// File: doc/BRIEF.md
# Two-Cycle Peripheral Bus Bridge

The bridge sits between a 32-bit system bus master and a 16-bit on-chip peripheral bus. The master raises a request with an address, a direction, an access size and write data. The bridge then checks the address against eight peripheral windows of 256 bytes each. The windows lie one after another above a base address. A request that falls inside a window takes exactly two clocks. In the first clock the address is decoded and ready stays low. In the second clock the chip select of that window is asserted alone, and the transfer happens on the peripheral bus while ready is high.

A request outside every window never reaches the peripheral bus. It completes in the same clock with ready and an error flag, and its read data is zero. Each window is configured as 8-bit or 16-bit. Read data from an 8-bit window is zero-extended, and the system side always gets zero in bits 31:16. On writes, a pair of byte strobes tells the peripheral which lanes of the 16-bit data carry valid bytes. This allows one half of a 16-bit register to be written at a time.

Top module: `pbus_bridge`

## Requirements
- R1: While reset is held, all chip selects, both byte strobes, the peripheral write flag, ready and error are low.
- R2: A request whose address matches the window base in bits 31:11 is a hit. Ready stays low in the request clock. In the next clock, ready is high for one clock and exactly one chip select is high, at the index given by address bits 10:8. After that clock, all chip selects are low.
- R3: A request outside all windows raises ready and error in the same clock. It returns read data zero and asserts no chip select, no strobe and no peripheral write.
- R4: A byte write (size code 0) asserts strobe bit 0 when address bit 0 is 0 and strobe bit 1 when it is 1. The data byte from system bits 7:0 is driven on both lanes.
- R5: A halfword write (size code 1) or word write (size code 2 or 3) asserts both strobes and drives system write bits 15:0.
- R6: A read asserts neither strobe, keeps the peripheral write flag low and drives zero write data.
- R7: A read from a 16-bit window returns the 16-bit peripheral read data in bits 15:0 and zero above it.
- R8: A read from an 8-bit window returns peripheral read bits 7:0 and zero in bits 31:8.
- R9: During the access clock, the peripheral address equals system address bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_req | input | 1 | Access request from the system master |
| sys_we | input | 1 | 1 = write, 0 = read |
| sys_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| sys_addr | input | 32 | Byte address |
| sys_wdata | input | 32 | Write data |
| sys_rdata | output | 32 | Read data, valid while sys_ready is high |
| sys_ready | output | 1 | Access completes in this clock |
| sys_err | output | 1 | Address hit no peripheral window |
| pb_cs | output | 8 | One-hot peripheral chip selects |
| pb_addr | output | 8 | Register offset inside the window |
| pb_we | output | 1 | Peripheral write flag |
| pb_bs | output | 2 | Byte strobes: bit 0 low lane, bit 1 high lane |
| pb_wdata | output | 16 | Peripheral write data |
| pb_rdata | input | 16 | Read data from the selected peripheral |

## Verification
The assertions assume that the master keeps its request at most until it sees ready. Once ready appears, a new request is not presented until the clock after it. The bench keeps to this rule: its driver holds each request for exactly one clock and then drops it. Back-to-back hits therefore always have the completion clock between them. The assertions also assume that peripheral read data is meaningful only while a chip select is high. The bench changes that data only when it presents a new request, and never during an access.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACCESS = 1'b1
    } br_state_e;

endpackage

// File: rtl/pbus_decode.sv
module pbus_decode #(
    parameter int          ADDR_W   = 32,
    parameter int          N_WIN    = 8,
    parameter int          WIN_BITS = 8,
    parameter logic [31:0] BASE     = 32'h4000_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [N_WIN-1:0]  sel
);
    localparam int IDX_W     = $clog2(N_WIN);
    localparam int MATCH_LSB = WIN_BITS + IDX_W;

    logic [IDX_W-1:0] idx;

    assign hit = (addr[ADDR_W-1:MATCH_LSB] == BASE[ADDR_W-1:MATCH_LSB]);
    assign idx = addr[MATCH_LSB-1:WIN_BITS];

    for (genvar i = 0; i < N_WIN; i++) begin : g_sel
        assign sel[i] = hit && (idx == IDX_W'(i));
    end
endmodule

// File: rtl/pbus_lane.sv
module pbus_lane
    import pbus_pkg::*;
#(
    parameter int SYS_W = 32,
    parameter int PB_W  = 16
) (
    input  logic             we,
    input  logic [1:0]       size,
    input  logic             addr0,
    input  logic [SYS_W-1:0] wdata,
    output logic [1:0]       bs,
    output logic [PB_W-1:0]  pdata
);
    localparam int LANE_W = PB_W / 2;

    acc_size_e sz;
    assign sz = acc_size_e'(size);

    always_comb begin
        bs    = 2'b00;
        pdata = '0;
        if (we) begin
            if (sz == SZ_BYTE) begin
                bs    = addr0 ? 2'b10 : 2'b01;
                pdata = {wdata[LANE_W-1:0], wdata[LANE_W-1:0]};
            end else begin
                bs    = 2'b11;
                pdata = wdata[PB_W-1:0];
            end
        end
    end
endmodule

// File: rtl/pbus_bridge.sv
module pbus_bridge
    import pbus_pkg::*;
#(
    parameter int             SYS_W     = 32,
    parameter int             PB_W      = 16,
    parameter int             N_PERIPH  = 8,
    parameter int             WIN_BITS  = 8,
    parameter logic [31:0]    PB_BASE   = 32'h4000_0000,
    parameter logic [7:0]     WIDE_MASK = 8'b0000_1111
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sys_req,
    input  logic                sys_we,
    input  logic [1:0]          sys_size,
    input  logic [SYS_W-1:0]    sys_addr,
    input  logic [SYS_W-1:0]    sys_wdata,
    output logic [SYS_W-1:0]    sys_rdata,
    output logic                sys_ready,
    output logic                sys_err,
    output logic [N_PERIPH-1:0] pb_cs,
    output logic [WIN_BITS-1:0] pb_addr,
    output logic                pb_we,
    output logic [1:0]          pb_bs,
    output logic [PB_W-1:0]     pb_wdata,
    input  logic [PB_W-1:0]     pb_rdata
);
    localparam int NARROW_W = PB_W / 2;

    typedef struct packed {
        br_state_e              state;
        logic [N_PERIPH-1:0]    cs;
        logic [WIN_BITS-1:0]    addr;
        logic [PB_W-1:0]        wdata;
        logic [1:0]             bs;
        logic                   we;
        logic                   wide;
    } br_regs_t;

    br_regs_t r_d, r_q;

    logic                hit;
    logic [N_PERIPH-1:0] sel;
    logic [1:0]          lane_bs;
    logic [PB_W-1:0]     lane_data;
    logic                take;

    pbus_decode #(
        .ADDR_W  (SYS_W),
        .N_WIN   (N_PERIPH),
        .WIN_BITS(WIN_BITS),
        .BASE    (PB_BASE)
    ) u_decode (
        .addr(sys_addr),
        .hit (hit),
        .sel (sel)
    );

    pbus_lane #(
        .SYS_W(SYS_W),
        .PB_W (PB_W)
    ) u_lane (
        .we   (sys_we),
        .size (sys_size),
        .addr0(sys_addr[0]),
        .wdata(sys_wdata),
        .bs   (lane_bs),
        .pdata(lane_data)
    );

    assign take = (r_q.state == ST_IDLE) && sys_req;

    always_comb begin
        r_d = '0;
        r_d.state = ST_IDLE;
        if (take && hit) begin
            r_d.state = ST_ACCESS;
            r_d.cs    = sel;
            r_d.addr  = sys_addr[WIN_BITS-1:0];
            r_d.wdata = lane_data;
            r_d.bs    = lane_bs;
            r_d.we    = sys_we;
            r_d.wide  = |(sel & WIDE_MASK);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign pb_cs    = r_q.cs;
    assign pb_addr  = r_q.addr;
    assign pb_we    = r_q.we;
    assign pb_bs    = r_q.bs;
    assign pb_wdata = r_q.wdata;

    assign sys_err   = take && !hit;
    assign sys_ready = (r_q.state == ST_ACCESS) || sys_err;

    always_comb begin
        sys_rdata = '0;
        if (r_q.state == ST_ACCESS && !r_q.we) begin
            if (r_q.wide)
                sys_rdata[PB_W-1:0] = pb_rdata;
            else
                sys_rdata[NARROW_W-1:0] = pb_rdata[NARROW_W-1:0];
        end
    end
endmodule

// File: rtl/pbus_bridge_chk.sv
module pbus_bridge_chk #(
    parameter int         SYS_W     = 32,
    parameter int         N_PERIPH  = 8,
    parameter logic [7:0] WIDE_MASK = 8'b0000_1111
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sys_req,
    input logic [SYS_W-1:0]    sys_rdata,
    input logic                sys_ready,
    input logic                sys_err,
    input logic [N_PERIPH-1:0] pb_cs,
    input logic                pb_we,
    input logic [1:0]          pb_bs
);
    assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pb_cs));

    assert_cs_one_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_cs != '0) |=> (pb_cs == '0));

    assert_cs_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_cs != '0) |-> $past(sys_req));

    assert_cs_with_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_cs != '0) |-> (sys_ready && !sys_err));

    assert_miss_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sys_err |-> (sys_ready && sys_rdata == '0 && pb_cs == '0 && pb_bs == 2'b00));

    assert_strobe_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_bs != 2'b00) |-> (pb_we && pb_cs != '0));

    assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rdata[SYS_W-1:16] == '0);

    assert_narrow_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (((pb_cs & ~WIDE_MASK) != '0) && !pb_we) |-> (sys_rdata[SYS_W-1:8] == '0));
endmodule

bind pbus_bridge pbus_bridge_chk #(
    .SYS_W    (SYS_W),
    .N_PERIPH (N_PERIPH),
    .WIDE_MASK(WIDE_MASK)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sys_req  (sys_req),
    .sys_rdata(sys_rdata),
    .sys_ready(sys_ready),
    .sys_err  (sys_err),
    .pb_cs    (pb_cs),
    .pb_we    (pb_we),
    .pb_bs    (pb_bs)
);

// File: tb/test_pbus_bridge.sv
module test_pbus_bridge;
    localparam logic [31:0] BASE = 32'h4000_0000;
    localparam logic [7:0]  WIDE = 8'b0000_1111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sys_req = 1'b0;
    logic        sys_we = 1'b0;
    logic [1:0]  sys_size = 2'd0;
    logic [31:0] sys_addr = '0;
    logic [31:0] sys_wdata = '0;
    logic [31:0] sys_rdata;
    logic        sys_ready;
    logic        sys_err;
    logic [7:0]  pb_cs;
    logic [7:0]  pb_addr;
    logic        pb_we;
    logic [1:0]  pb_bs;
    logic [15:0] pb_wdata;
    logic [15:0] pb_rdata = '0;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic        hit;
        logic        err;
        logic [31:0] rdata;
        logic [7:0]  cs;
        logic [1:0]  bs;
        logic        we;
        logic [7:0]  paddr;
        logic [15:0] pwdata;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;

    pbus_bridge i_pbus_bridge (
        .clk(clk), .rst_n(rst_n), .sys_req(sys_req), .sys_we(sys_we),
        .sys_size(sys_size), .sys_addr(sys_addr), .sys_wdata(sys_wdata),
        .sys_rdata(sys_rdata), .sys_ready(sys_ready), .sys_err(sys_err),
        .pb_cs(pb_cs), .pb_addr(pb_addr), .pb_we(pb_we), .pb_bs(pb_bs),
        .pb_wdata(pb_wdata), .pb_rdata(pb_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [1:0] sz, input logic [31:0] a,
                          input logic [31:0] wd, input logic [15:0] prd, input string tag);
        exp_t e;
        logic [2:0] idx;
        @(negedge clk);
        e.hit = (a[31:11] == BASE[31:11]);
        idx = a[10:8];
        e.err = !e.hit;
        e.cs = e.hit ? (8'd1 << idx) : 8'd0;
        e.we = e.hit && we;
        e.paddr = e.hit ? a[7:0] : 8'd0;
        e.bs = 2'b00;
        e.pwdata = '0;
        if (e.hit && we) begin
            if (sz == 2'd0) begin
                e.bs = a[0] ? 2'b10 : 2'b01;
                e.pwdata = {wd[7:0], wd[7:0]};
            end else begin
                e.bs = 2'b11;
                e.pwdata = wd[15:0];
            end
        end
        e.rdata = '0;
        if (e.hit && !we)
            e.rdata = WIDE[idx] ? {16'h0, prd} : {24'h0, prd[7:0]};
        e.tag = tag;
        sb.push_back(e);
        pb_rdata = prd;
        sys_we = we; sys_size = sz; sys_addr = a; sys_wdata = wd; sys_req = 1'b1;
        #5;
        if (e.hit) check({"R2 ready low in decode clock ", tag}, 32'(sys_ready), 32'd0);
        @(negedge clk);
        sys_req = 1'b0;
    endtask

    // monitor: pops one expected item per completion
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (rst_n) begin
                if (sys_ready) begin
                    if (sb.size() == 0) begin
                        check("R2 unexpected ready", 32'(sys_ready), 32'd0);
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        check({"R3 err ", e.tag}, 32'(sys_err), 32'(e.err));
                        check({"R7/R8 rdata ", e.tag}, sys_rdata, e.rdata);
                        check({"R2 cs ", e.tag}, 32'(pb_cs), 32'(e.cs));
                        check({"R4/R5/R6 bs ", e.tag}, 32'(pb_bs), 32'(e.bs));
                        check({"R6 we ", e.tag}, 32'(pb_we), 32'(e.we));
                        if (e.hit) begin
                            check({"R9 addr ", e.tag}, 32'(pb_addr), 32'(e.paddr));
                            check({"R4/R5/R6 wdata ", e.tag}, 32'(pb_wdata), 32'(e.pwdata));
                        end
                    end
                end else begin
                    check("R2 bus idle without access", {22'd0, pb_cs, pb_bs}, 32'd0);
                end
            end
        end
    end

    initial begin
        #4_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 cs in reset", 32'(pb_cs), 32'd0);
        check("R1 bs in reset", 32'(pb_bs), 32'd0);
        check("R1 we in reset", 32'(pb_we), 32'd0);
        check("R1 ready in reset", 32'(sys_ready), 32'd0);
        check("R1 err in reset", 32'(sys_err), 32'd0);
        rst_n = 1'b1;

        access(1'b1, 2'd0, BASE + 32'h0010, 32'h0000_00A5, 16'h0, "R4 byte low lane");
        access(1'b1, 2'd0, BASE + 32'h0011, 32'h0000_003C, 16'h0, "R4 byte high lane");
        access(1'b1, 2'd1, BASE + 32'h0120, 32'h1234_BEEF, 16'h0, "R5 halfword");
        access(1'b1, 2'd2, BASE + 32'h07FC, 32'hCAFE_F00D, 16'h0, "R5 word to narrow window 7");
        access(1'b1, 2'd3, BASE + 32'h0302, 32'h0000_5A5A, 16'h0, "R5 size code 3");
        access(1'b0, 2'd1, BASE + 32'h0244, 32'hFFFF_FFFF, 16'hD00D, "R7 wide read");
        access(1'b0, 2'd1, BASE + 32'h0508, 32'h0, 16'hABCD, "R8 narrow read");
        access(1'b0, 2'd0, BASE + 32'h06FF, 32'h0, 16'hFF81, "R8 narrow byte read");
        access(1'b0, 2'd2, BASE + 32'h03FE, 32'h0, 16'h8001, "R7 word read wide");
        access(1'b0, 2'd1, BASE - 32'h2, 32'h0, 16'h7777, "R3 miss below base");
        access(1'b1, 2'd1, BASE + 32'h0800, 32'h1111, 16'h0, "R3 miss past windows");
        access(1'b0, 2'd0, 32'h0000_0000, 32'h0, 16'h4444, "R3 miss at zero");
        access(1'b1, 2'd0, BASE + 32'h0401, 32'h0000_0077, 16'h0, "R4 byte high window 4");
        access(1'b0, 2'd1, BASE + 32'h0100, 32'h0, 16'h0F0F, "R7 back to back");

        repeat (4) @(negedge clk);
        check("R2 all completions seen", 32'(sb.size()), 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule